// File: doc/BRIEF.md
# Four-channel interval timer bank

A register-mapped block holding four identical up-counting timer channels. Each channel advances only on the cycles where its own tick-enable input is high. The intended tick rates are about 32.768 kHz for channel 0, 1 kHz for channel 1, and 1 MHz for channels 2 and 3. Those enables come from outside the block; the channels themselves are identical. Software drives a channel through command locations: a write of any data to one of them performs an action. Other locations set the mode, set the terminal count, set the interrupt enable and acknowledge the interrupt. A packed status word shows the channel state, and each channel drives its own interrupt line.

A channel in continuous mode restarts from zero after it reaches its terminal count, so it fires at a fixed period. A channel in one-shot mode stops at the terminal count and becomes idle. If the terminal count is all ones, a continuous channel behaves as a free-running counter, which makes it usable as a timestamp source. One global register holds a clock-request bit.

Top module: `tmr_bank`

## Requirements
- R1: Addresses are byte addresses. Channel n occupies 0x40*n to 0x40*n+0x3F, and the global register sits at 0x100. Any address whose low two bits are nonzero is unmapped. Reads of write-only locations, and reads of unmapped locations, return zero. The value read is captured at the clock edge where rd_en is high and is shown on rdata from then on.
- R2: A write with any data to channel offset 0x0 clears the channel, a write to 0x4 starts it, and a write to 0x8 stops it. A stopped channel keeps its count.
- R3: Offset 0xC is write-only. Its bit 0 selects the mode: 0 is continuous and 1 is one-shot.
- R4: On each cycle where the channel is running and its tick_en bit is high, the count at offset 0x14 goes up by one. A stopped channel ignores ticks, and the tick bits of other channels have no effect on it.
- R5: A channel raises its pending flag when its count steps onto the terminal count. In continuous mode, the next tick after that moves the count to 0, so the period is terminal count + 1 ticks.
- R6: In one-shot mode, when the count steps onto the terminal count, the channel stops, holds its count at the terminal count, and reports idle.
- R7: The clear command sets the count to 0, clears pending and stops the channel. It keeps the terminal count, the mode and the interrupt enable.
- R8: The status word at offset 0x10 is read-only. Bits [3:0] hold 1 when idle and 2 when running. Bit 4 is set while running, bit 5 is set in one-shot mode, bit 6 is the interrupt enable and bit 7 is pending. All higher bits are 0.
- R9: Offset 0x1C is write-only, and its bit 0 sets the interrupt enable. irq[n] is high exactly when channel n has pending set and its interrupt enabled.
- R10: A write to offset 0x20 with bit 7 set clears pending. The other bits of that write have no effect. If a terminal-count event happens in the same cycle, pending stays set.
- R11: Offset 0x18 holds the terminal count and can be read and written. With a terminal count of 1, a running channel becomes pending after a single tick.
- R12: In continuous mode with an all-ones terminal count, the counter covers the full CW-bit range and wraps from all ones to 0.
- R13: The register at 0x100 can be read and written. Its bit 0 drives clk_req, and reads of it return that bit alone.
- R14: Synchronous active-high reset puts every channel into this state: count 0, terminal count all ones, continuous mode, interrupt disabled, not pending, idle. After reset clk_req, irq and rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (9) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tick_en | input | NCH (4) | Per-channel count enables |
| irq | output | NCH (4) | Per-channel interrupt lines |
| clk_req | output | 1 | Clock-request enable bit |

## Verification
The bench targets the terminal-count edges. It checks that a continuous channel goes to zero on the tick after it reaches the terminal count, not on the same tick. An off-by-one here would shift the period or lose the pending event. It also checks that a one-shot channel stops exactly at the terminal count, where a wrong design would keep counting or restart. The reset command must keep the configuration, and a design that cleared it would show up in the status and terminal-count reads. An acknowledge that coincides with an event must keep pending set, or an interrupt would be lost. A second instance with an 8-bit counter shows the all-ones wrap, which is too long to reach at 32 bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // byte span of one channel window (0x40)
    localparam int CH_SPAN_W = 6;

    // word index inside a channel window
    localparam logic [3:0] W_CLEAR  = 4'd0;
    localparam logic [3:0] W_START  = 4'd1;
    localparam logic [3:0] W_STOP   = 4'd2;
    localparam logic [3:0] W_MODE   = 4'd3;
    localparam logic [3:0] W_STATUS = 4'd4;
    localparam logic [3:0] W_COUNT  = 4'd5;
    localparam logic [3:0] W_LIMIT  = 4'd6;
    localparam logic [3:0] W_IRQEN  = 4'd7;
    localparam logic [3:0] W_ACK    = 4'd8;

    localparam int ACK_BIT = 7;

    localparam logic [3:0] ST_IDLE = 4'd1;
    localparam logic [3:0] ST_RUN  = 4'd2;

    typedef enum logic {
        MODE_CONT    = 1'b0,
        MODE_ONESHOT = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic clear;
        logic start;
        logic stop;
        logic set_mode;
        logic set_limit;
        logic set_irqen;
        logic ack;
    } tmr_cmd_t;

    function automatic logic [31:0] pack_status(input logic run, input tmr_mode_e m,
                                                input logic ie, input logic pend);
        return {24'd0, pend, ie, (m == MODE_ONESHOT), run, (run ? ST_RUN : ST_IDLE)};
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 9
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    output logic [NCH-1:0] ch_sel,
    output logic [3:0]    word,
    output logic          glob_sel,
    output tmr_cmd_t      cmd [NCH]
);
    localparam int SEL_W = AW - CH_SPAN_W;

    logic             aligned;
    logic [SEL_W-1:0] win;

    assign aligned  = (addr[1:0] == 2'b00);
    assign win      = addr[AW-1:CH_SPAN_W];
    assign word     = addr[CH_SPAN_W-1:2];
    assign glob_sel = aligned && (win == SEL_W'(NCH)) && (word == 4'd0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_wr;
        assign ch_sel[i]        = aligned && (win == SEL_W'(i));
        assign hit_wr           = wr_en && ch_sel[i];
        assign cmd[i].clear     = hit_wr && (word == W_CLEAR);
        assign cmd[i].start     = hit_wr && (word == W_START);
        assign cmd[i].stop      = hit_wr && (word == W_STOP);
        assign cmd[i].set_mode  = hit_wr && (word == W_MODE);
        assign cmd[i].set_limit = hit_wr && (word == W_LIMIT);
        assign cmd[i].set_irqen = hit_wr && (word == W_IRQEN);
        assign cmd[i].ack       = hit_wr && (word == W_ACK);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  tmr_cmd_t      cmd,
    input  logic [CW-1:0] wval,
    input  logic          wbit0,
    input  logic          wbit_ack,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lim,
    output logic          run,
    output tmr_mode_e     mode,
    output logic          irq_en,
    output logic          pend
);
    logic          ctl_cmd;
    logic          step;
    logic [CW-1:0] nxt;
    logic          fire;

    always_comb begin
        ctl_cmd = cmd.clear | cmd.start | cmd.stop;
        step    = run && tick && !ctl_cmd;
        nxt     = (cnt == lim) ? '0 : cnt + 1'b1;
        fire    = step && (nxt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lim    <= '1;
            run    <= 1'b0;
            mode   <= MODE_CONT;
            irq_en <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (cmd.clear) begin
                cnt <= '0;
                run <= 1'b0;
            end else if (cmd.stop) begin
                run <= 1'b0;
            end else if (cmd.start) begin
                run <= 1'b1;
            end else if (step) begin
                cnt <= nxt;
                if (fire && mode == MODE_ONESHOT)
                    run <= 1'b0;
            end

            if (cmd.set_mode)  mode   <= tmr_mode_e'(wbit0);
            if (cmd.set_limit) lim    <= wval;
            if (cmd.set_irqen) irq_en <= wbit0;

            if (cmd.clear)
                pend <= 1'b0;
            else if (fire)
                pend <= 1'b1;
            else if (cmd.ack && wbit_ack)
                pend <= 1'b0;
        end
    end

    // R4: a stopped channel holds its count unless cleared
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cmd.clear) |=> $stable(cnt));

    // R6: a one-shot event leaves the channel stopped at its terminal count
    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        ($rose(pend) && $past(mode == MODE_ONESHOT) && !$past(cmd.set_limit))
        |-> (!run && cnt == lim));

    // R7: clear command empties count, pending and run state
    a_r7_clear_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (cnt == '0 && !run && !pend));

    // R10: an acknowledge with no coincident event drops pending
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && wbit_ack && !fire) |=> !pend);

endmodule

// File: rtl/tmr_readmux.sv
module tmr_readmux
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [NCH-1:0] ch_sel,
    input  logic [3:0]     word,
    input  logic           glob_sel,
    input  logic [31:0]    status [NCH],
    input  logic [CW-1:0]  cnt    [NCH],
    input  logic [CW-1:0]  lim    [NCH],
    input  logic           clk_req,
    output logic [31:0]    rdata
);
    logic [31:0] rval;

    always_comb begin
        rval = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) begin
                case (word)
                    W_STATUS: rval = status[i];
                    W_COUNT:  rval = 32'(cnt[i]);
                    W_LIMIT:  rval = 32'(lim[i]);
                    default:  rval = '0;
                endcase
            end
        end
        if (glob_sel)
            rval = {31'd0, clk_req};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rval;
    end

    // R1: data only changes in the cycle after a read strobe
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    localparam int AW = CH_SPAN_W + $clog2(NCH) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic [NCH-1:0] tick_en,
    output logic [NCH-1:0] irq,
    output logic           clk_req
);
    logic [NCH-1:0] ch_sel;
    logic [3:0]     word;
    logic           glob_sel;
    tmr_cmd_t       cmd    [NCH];
    logic [31:0]    status [NCH];
    logic [CW-1:0]  cnt    [NCH];
    logic [CW-1:0]  lim    [NCH];

    tmr_decode #(.NCH(NCH), .AW(AW)) u_decode (
        .addr     (addr),
        .wr_en    (wr_en),
        .ch_sel   (ch_sel),
        .word     (word),
        .glob_sel (glob_sel),
        .cmd      (cmd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic      run;
        tmr_mode_e mode;
        logic      irq_en;
        logic      pend;

        tmr_channel #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_en[i]),
            .cmd      (cmd[i]),
            .wval     (wdata[CW-1:0]),
            .wbit0    (wdata[0]),
            .wbit_ack (wdata[ACK_BIT]),
            .cnt      (cnt[i]),
            .lim      (lim[i]),
            .run      (run),
            .mode     (mode),
            .irq_en   (irq_en),
            .pend     (pend)
        );

        assign status[i] = pack_status(run, mode, irq_en, pend);
        assign irq[i]    = pend & irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            clk_req <= 1'b0;
        else if (wr_en && glob_sel)
            clk_req <= wdata[0];
    end

    tmr_readmux #(.NCH(NCH), .CW(CW)) u_readmux (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .ch_sel   (ch_sel),
        .word     (word),
        .glob_sel (glob_sel),
        .status   (status),
        .cnt      (cnt),
        .lim      (lim),
        .clk_req  (clk_req),
        .rdata    (rdata)
    );

    // R13: the global bit follows the last write to it
    a_r13_clk_req_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && glob_sel) |=> (clk_req == $past(wdata[0])));

endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
    localparam int NVEC = 56;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  addr;   // for ticks: channel mask
        logic [31:0] data;   // for ticks: count
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // channel 2 lives at 0x80, channel 0 at 0x00, channel 3 at 0xC0
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD, 9'h090, 32'h0, 32'h01, 8'd14},          // R14 R8 idle after reset
        '{OP_RD, 9'h098, 32'h0, 32'hFFFFFFFF, 8'd14},    // R14 limit all ones
        '{OP_WR, 9'h098, 32'd5, 32'h0, 8'd11},
        '{OP_RD, 9'h098, 32'h0, 32'd5, 8'd11},           // R11 limit readback
        '{OP_WR, 9'h084, 32'hDEAD, 32'h0, 8'd2},         // R2 start, data ignored
        '{OP_RD, 9'h090, 32'h0, 32'h12, 8'd8},           // R8 running
        '{OP_TK, 9'h004, 32'd3, 32'h0, 8'd4},
        '{OP_RD, 9'h094, 32'h0, 32'd3, 8'd4},            // R4 counts ticks
        '{OP_TK, 9'h001, 32'd2, 32'h0, 8'd4},
        '{OP_RD, 9'h094, 32'h0, 32'd3, 8'd4},            // R4 foreign ticks ignored
        '{OP_TK, 9'h004, 32'd2, 32'h0, 8'd5},
        '{OP_RD, 9'h090, 32'h0, 32'h92, 8'd5},           // R5 pending at limit
        '{OP_RD, 9'h094, 32'h0, 32'd5, 8'd5},
        '{OP_TK, 9'h004, 32'd1, 32'h0, 8'd5},
        '{OP_RD, 9'h094, 32'h0, 32'd0, 8'd5},            // R5 wrap on next tick
        '{OP_WR, 9'h0A0, 32'h7F, 32'h0, 8'd10},
        '{OP_RD, 9'h090, 32'h0, 32'h92, 8'd10},          // R10 ack without bit 7
        '{OP_WR, 9'h0A0, 32'h80, 32'h0, 8'd10},
        '{OP_RD, 9'h090, 32'h0, 32'h12, 8'd10},          // R10 ack clears
        '{OP_WR, 9'h08C, 32'd1, 32'h0, 8'd3},
        '{OP_RD, 9'h090, 32'h0, 32'h32, 8'd3},           // R3 one-shot shown
        '{OP_TK, 9'h004, 32'd5, 32'h0, 8'd6},
        '{OP_RD, 9'h090, 32'h0, 32'hA1, 8'd6},           // R6 idle + pending
        '{OP_RD, 9'h094, 32'h0, 32'd5, 8'd6},
        '{OP_TK, 9'h004, 32'd2, 32'h0, 8'd6},
        '{OP_RD, 9'h094, 32'h0, 32'd5, 8'd6},            // R6 holds at limit
        '{OP_WR, 9'h09C, 32'd1, 32'h0, 8'd9},
        '{OP_RD, 9'h090, 32'h0, 32'hE1, 8'd9},           // R9 enable shown
        '{OP_WR, 9'h080, 32'hFFFFFFFF, 32'h0, 8'd7},
        '{OP_RD, 9'h090, 32'h0, 32'h61, 8'd7},           // R7 config kept
        '{OP_RD, 9'h094, 32'h0, 32'd0, 8'd7},
        '{OP_RD, 9'h098, 32'h0, 32'd5, 8'd7},
        '{OP_WR, 9'h084, 32'h0, 32'h0, 8'd2},
        '{OP_TK, 9'h004, 32'd2, 32'h0, 8'd2},
        '{OP_WR, 9'h088, 32'h0, 32'h0, 8'd2},
        '{OP_TK, 9'h004, 32'd3, 32'h0, 8'd2},
        '{OP_RD, 9'h094, 32'h0, 32'd2, 8'd2},            // R2 stop freezes count
        '{OP_RD, 9'h084, 32'h0, 32'h0, 8'd1},            // R1 write-only reads 0
        '{OP_RD, 9'h0A4, 32'h0, 32'h0, 8'd1},
        '{OP_RD, 9'h104, 32'h0, 32'h0, 8'd1},
        '{OP_RD, 9'h08C, 32'h0, 32'h0, 8'd1},
        '{OP_WR, 9'h100, 32'd3, 32'h0, 8'd13},
        '{OP_RD, 9'h100, 32'h0, 32'd1, 8'd13},           // R13
        '{OP_WR, 9'h080, 32'h0, 32'h0, 8'd11},
        '{OP_WR, 9'h08C, 32'h0, 32'h0, 8'd11},
        '{OP_WR, 9'h098, 32'd1, 32'h0, 8'd11},
        '{OP_WR, 9'h084, 32'h0, 32'h0, 8'd11},
        '{OP_TK, 9'h004, 32'd1, 32'h0, 8'd11},
        '{OP_RD, 9'h090, 32'h0, 32'hD2, 8'd11},          // R11 one tick to event
        '{OP_RD, 9'h094, 32'h0, 32'd1, 8'd11},
        '{OP_WR, 9'h018, 32'd3, 32'h0, 8'd1},
        '{OP_WR, 9'h004, 32'h0, 32'h0, 8'd1},
        '{OP_TK, 9'h001, 32'd2, 32'h0, 8'd1},
        '{OP_RD, 9'h014, 32'h0, 32'd2, 8'd1},            // R1 channel 0 window
        '{OP_WR, 9'h0D8, 32'd9, 32'h0, 8'd1},
        '{OP_RD, 9'h0D8, 32'h0, 32'd9, 8'd1}             // R1 channel 3 window
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  tick_en = '0;
    logic [31:0] rdata, rdata_w;
    logic [3:0]  irq, irq_w;
    logic        clk_req, clk_req_w;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tmr_bank i_tmr_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq), .clk_req(clk_req)
    );

    tmr_bank #(.CW(8)) i_tmr_bank_w8 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_w), .tick_en(tick_en), .irq(irq_w), .clk_req(clk_req_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tk(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = m;
            @(negedge clk); tick_en = '0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v].op)
                OP_WR: wr(VEC[v].addr, VEC[v].data);
                OP_TK: tk(VEC[v].addr[3:0], int'(VEC[v].data));
                default: begin
                    rd(VEC[v].addr);
                    check($sformatf("R%0d vec%0d", VEC[v].req, v), rdata, VEC[v].exp);
                end
            endcase
        end

        // R14: reset values at the ports
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R14 irq", 32'(irq), 32'h0);
        check("R14 clk_req", 32'(clk_req), 32'h0);
        check("R14 rdata", rdata, 32'h0);

        // R9: interrupt gating on channel 1
        wr(9'h058, 32'd1);
        wr(9'h044, 32'd0);
        tk(4'b0010, 1);
        check("R9 irq masked", 32'(irq), 32'h0);
        wr(9'h05C, 32'd1);
        check("R9 irq raised", 32'(irq), 32'h2);
        wr(9'h05C, 32'd0);
        check("R9 irq masked again", 32'(irq), 32'h0);
        wr(9'h05C, 32'd1);
        check("R9 pending kept", 32'(irq), 32'h2);

        // R10: event in the same cycle as acknowledge keeps pending
        wr(9'h040, 32'd0);
        check("R7 clear drops irq", 32'(irq), 32'h0);
        wr(9'h058, 32'd0);
        wr(9'h044, 32'd0);
        @(negedge clk); wr_en = 1'b1; addr = 9'h060; wdata = 32'h80; tick_en = 4'b0010;
        @(negedge clk); wr_en = 1'b0; tick_en = '0;
        check("R10 event beats ack", 32'(irq), 32'h2);
        wr(9'h060, 32'h80);
        check("R10 ack alone", 32'(irq), 32'h0);

        // R12: full-range wrap on the 8-bit instance, channel 3
        wr(9'h0C4, 32'd0);
        tk(4'b1000, 255);
        rd(9'h0D4);
        check("R12 count at all ones", rdata_w, 32'hFF);
        rd(9'h0D0);
        check("R12 pending at all ones", rdata_w, 32'h92);
        tk(4'b1000, 1);
        rd(9'h0D4);
        check("R12 wrapped to zero", rdata_w, 32'h0);
        check("R4 wide counter keeps counting", rdata, 32'h100);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule